// File: doc/BRIEF.md
# Interrupt Enable and Dispatch Controller

This block sits in the sequencer of a small 8-bit processor and makes one decision at every instruction boundary: let the core fetch the next opcode, or send it to an interrupt handler. It owns the master interrupt enable, a two-step delayed-enable path for the enable instruction, and the halted state. Five interrupt sources are seen through an enable register and a flag register. Both arrive as inputs, and their bitwise AND gives the pending set.

The core pulses `boundary` in every cycle in which it is about to fetch. While halted, it pulses `boundary` in every machine cycle. Decode strobes for the enable, disable, return-from-interrupt and halt instructions arrive during execution cycles. When an interrupt is taken, the block raises `dispatchReq` for that boundary cycle. In the same cycle it presents the handler address and a one-hot mask naming the flag bit to clear. It then holds `dispatchBusy` for the length of the dispatch sequence.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset the master enable and both delayed-enable stages are off. `halted`, `dispatchBusy` and `dispatchReq` are 0, and `vectorAddr` and `flagClear` are 0.
- R2: An interrupt is taken at a boundary only when the effective enable is on and `enableMask & flagBits` is non-zero. With the enable off, a boundary never raises `dispatchReq`.
- R3: On a dispatch, the lowest-numbered pending bit wins. `vectorAddr` = 0x0040 + 8 × bit index (bit 0 gives 0x0040, bit 1 gives 0x0048, bit 2 gives 0x0050, bit 3 gives 0x0058, bit 4 gives 0x0060). `flagClear` has only that bit set. Both outputs are 0 in any cycle without `dispatchReq`.
- R4: A dispatch turns the master enable off, so a following boundary with sources still pending does not dispatch.
- R5: `dispatchBusy` is 1 for exactly 5 cycles, starting in the cycle after `dispatchReq`. Boundaries during those cycles are not evaluated.
- R6: After `eiStrobe`, the first boundary cannot dispatch. The enable becomes effective at the second boundary, and it applies to the interrupt check at that same boundary.
- R7: `diStrobe` turns the master enable off and cancels an enable that `eiStrobe` scheduled but that has not yet taken effect.
- R8: `retiStrobe` turns the master enable on at once, so the next boundary can dispatch.
- R9: `haltStrobe` sets `halted` in the next cycle. While no enabled source is pending, boundaries leave `halted` at 1.
- R10: A boundary while halted with a pending enabled source clears `halted` in the next cycle, even with the enable off. In that case there is no `dispatchReq`, and `flagClear` stays 0.
- R11: A boundary while halted with a pending source and the enable on clears `halted` and dispatches at that same boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| enableMask | input | 5 | Interrupt enable register contents |
| flagBits | input | 5 | Interrupt flag register contents |
| boundary | input | 1 | Instruction boundary strobe (every cycle while halted) |
| eiStrobe | input | 1 | Enable-interrupts instruction decoded |
| diStrobe | input | 1 | Disable-interrupts instruction decoded |
| retiStrobe | input | 1 | Return-from-interrupt instruction decoded |
| haltStrobe | input | 1 | Halt instruction decoded |
| dispatchReq | output | 1 | Interrupt taken at this boundary |
| vectorAddr | output | 16 | Handler address, valid with dispatchReq |
| flagClear | output | 5 | One-hot flag bit to clear, valid with dispatchReq |
| halted | output | 1 | Core is halted |
| dispatchBusy | output | 1 | Dispatch sequence in progress |

## Verification
The assertions take it that each decode strobe lasts one cycle and that at most one is high at a time. They also take it that no strobe coincides with a `boundary` cycle, and that none arrives while the block is halted or busy. The bench keeps to this by driving strobes only in execution cycles between boundaries, by sending only idle cycles while `dispatchBusy` is expected, and by sending only boundaries while halted. Random register values and instruction choices are mixed with directed sequences for each vector, for the enable delay, for cancellation by the disable instruction, and for both kinds of wake from halt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic take;   // interrupt accepted at this boundary
    logic wake;   // halted core released at this boundary
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int          NUM_SRC    = 5,
  parameter logic [15:0] VEC_BASE   = 16'h0040,
  parameter int          VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic [NUM_SRC-1:0] flagBits,
  input  ctrlStrobes_t       strobes,
  output logic               anyPending,
  output logic               dispatchReq,
  output logic [15:0]        vectorAddr,
  output logic [NUM_SRC-1:0] flagClear
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pending;
  logic [IDX_W-1:0]   winIdx;

  assign pending    = enableMask & flagBits;
  assign anyPending = |pending;

  // lowest-numbered pending source wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = IDX_W'(i);
    end
  end

  assign dispatchReq = strobes.take;
  assign vectorAddr  = strobes.take ? (VEC_BASE + 16'(winIdx) * 16'(VEC_STRIDE)) : 16'h0000;
  assign flagClear   = strobes.take ? (NUM_SRC'(1) << winIdx) : '0;

  // R3: at most one flag cleared, and only one that is raised
  assert_clear_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flagClear) && ((flagClear & ~flagBits) == '0));
  // R3: a dispatch always names a source and an aligned vector
  assert_vector_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> ($countones(flagClear) == 1 && vectorAddr >= VEC_BASE));
  // R10: a wake without a dispatch never clears a flag
  assert_wake_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wake && !strobes.take) |-> (flagClear == '0 && !dispatchReq));
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int DISPATCH_CYCLES = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         boundary,
  input  logic         eiStrobe,
  input  logic         diStrobe,
  input  logic         retiStrobe,
  input  logic         haltStrobe,
  input  logic         anyPending,
  output ctrlStrobes_t strobes,
  output logic         halted,
  output logic         dispatchBusy
);
  localparam int               CNT_W    = $clog2(DISPATCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DISPATCH_CYCLES);

  logic             ime;      // master enable
  logic             eiArm;    // enable decoded, first boundary not yet seen
  logic             eiRipe;   // promotes at the next boundary
  logic [CNT_W-1:0] busyCnt;
  logic             checkPoint;
  logic             promote;

  assign checkPoint   = boundary && (busyCnt == '0);
  assign promote      = checkPoint && eiRipe;
  assign strobes.take = checkPoint && (ime || eiRipe) && anyPending;
  assign strobes.wake = checkPoint && halted && anyPending;
  assign dispatchBusy = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ime     <= 1'b0;
      eiArm   <= 1'b0;
      eiRipe  <= 1'b0;
      halted  <= 1'b0;
      busyCnt <= '0;
    end else begin
      // boundary work: promotion first, then the interrupt check
      if (strobes.take)  ime <= 1'b0;
      else if (promote)  ime <= 1'b1;
      if (strobes.take || promote) eiRipe <= 1'b0;
      if (checkPoint && eiArm) begin
        eiRipe <= 1'b1;
        eiArm  <= 1'b0;
      end
      if (strobes.wake) halted <= 1'b0;
      if (strobes.take)          busyCnt <= CNT_LOAD;
      else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
      // decode strobes
      if (diStrobe) begin
        ime    <= 1'b0;
        eiArm  <= 1'b0;
        eiRipe <= 1'b0;
      end
      if (eiStrobe)   eiArm  <= 1'b1;
      if (retiStrobe) ime    <= 1'b1;
      if (haltStrobe) halted <= 1'b1;
    end
  end

  assert_take_drops_ime_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && !retiStrobe) |=> !ime);
  assert_busy_after_take_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> dispatchBusy);
  assert_busy_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispatchBusy) |-> $past(strobes.take));
  assert_ei_not_immediate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eiStrobe && !ime && !retiStrobe && !boundary) |=> !ime);
  assert_di_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (diStrobe && !retiStrobe) |=> (!ime && !eiArm && !eiRipe));
  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !anyPending) |=> halted);
  assert_wake_releases_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wake && !haltStrobe) |=> !halted);
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_pkg::*;
#(
  parameter int          NUM_SRC         = 5,
  parameter logic [15:0] VEC_BASE        = 16'h0040,
  parameter int          VEC_STRIDE      = 8,
  parameter int          DISPATCH_CYCLES = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic [NUM_SRC-1:0] flagBits,
  input  logic               boundary,
  input  logic               eiStrobe,
  input  logic               diStrobe,
  input  logic               retiStrobe,
  input  logic               haltStrobe,
  output logic               dispatchReq,
  output logic [15:0]        vectorAddr,
  output logic [NUM_SRC-1:0] flagClear,
  output logic               halted,
  output logic               dispatchBusy
);
  ctrlStrobes_t strobes;
  logic         anyPending;

  irq_control #(.DISPATCH_CYCLES(DISPATCH_CYCLES)) u_control (
    .clk(clk), .rstN(rstN), .boundary(boundary),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .retiStrobe(retiStrobe),
    .haltStrobe(haltStrobe), .anyPending(anyPending),
    .strobes(strobes), .halted(halted), .dispatchBusy(dispatchBusy)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_datapath (
    .clk(clk), .rstN(rstN), .enableMask(enableMask), .flagBits(flagBits),
    .strobes(strobes), .anyPending(anyPending), .dispatchReq(dispatchReq),
    .vectorAddr(vectorAddr), .flagClear(flagClear)
  );
endmodule

// File: tb/irq_dispatch_ctrl_bench.sv
module irq_dispatch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  enableMask = '0, flagBits = '0;
  logic        boundary = 1'b0, eiStrobe = 1'b0, diStrobe = 1'b0;
  logic        retiStrobe = 1'b0, haltStrobe = 1'b0;
  logic        dispatchReq, halted, dispatchBusy;
  logic [15:0] vectorAddr;
  logic [4:0]  flagClear;

  int checks = 0;
  int fails  = 0;

  // bench-side state derived from the requirements
  bit mIme, mArm, mRipe, mHalted;
  int mBusy;

  always #5 clk = ~clk;

  irq_dispatch_ctrl u_irq_dispatch_ctrl (
    .clk(clk), .rstN(rstN), .enableMask(enableMask), .flagBits(flagBits),
    .boundary(boundary), .eiStrobe(eiStrobe), .diStrobe(diStrobe),
    .retiStrobe(retiStrobe), .haltStrobe(haltStrobe), .dispatchReq(dispatchReq),
    .vectorAddr(vectorAddr), .flagClear(flagClear), .halted(halted),
    .dispatchBusy(dispatchBusy)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowestBit(input logic [4:0] p);
    for (int i = 0; i < 5; i++) if (p[i]) return i;
    return -1;
  endfunction

  // op: 0 none, 1 enable, 2 disable, 3 return, 4 halt
  task automatic stepCycle(input bit bnd, input int op, input logic [4:0] ie,
                           input logic [4:0] fl, input string tag);
    bit expAny, live, take;
    int low;
    @(negedge clk);
    boundary = bnd; enableMask = ie; flagBits = fl;
    eiStrobe = (op == 1); diStrobe = (op == 2); retiStrobe = (op == 3); haltStrobe = (op == 4);
    #1;
    expAny = |(ie & fl);
    low    = lowestBit(ie & fl);
    live   = bnd && (mBusy == 0);
    take   = live && (mIme || mRipe) && expAny;
    check(tag, "dispatchReq", int'(dispatchReq), int'(take));
    check(tag, "vectorAddr", int'(vectorAddr), take ? 16'h0040 + 8 * low : 0);
    check(tag, "flagClear", int'(flagClear), take ? (1 << low) : 0);
    check("R9", "halted", int'(halted), int'(mHalted));
    check("R5", "dispatchBusy", int'(dispatchBusy), int'(mBusy != 0));
    // advance the expected state for the coming edge
    if (take) begin mIme = 0; mRipe = 0; end
    else if (live && mRipe) begin mIme = 1; mRipe = 0; end
    if (live && mArm) begin mRipe = 1; mArm = 0; end
    if (live && mHalted && expAny) mHalted = 0;
    if (take) mBusy = 5; else if (mBusy > 0) mBusy--;
    if (op == 2) begin mIme = 0; mArm = 0; mRipe = 0; end
    if (op == 1) mArm = 1;
    if (op == 3) mIme = 1;
    if (op == 4) mHalted = 1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) stepCycle(0, 0, 5'h1f, 5'h00, "R5");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "dispatchReq", int'(dispatchReq), 0);
    check("R1", "halted", int'(halted), 0);
    check("R1", "dispatchBusy", int'(dispatchBusy), 0);
    check("R1", "vectorAddr", int'(vectorAddr), 0);
    check("R1", "flagClear", int'(flagClear), 0);
    rstN = 1'b1;
    stepCycle(1, 0, 5'h1f, 5'h01, "R1");          // enable still off after reset
    // R2: enable off, pending source: no dispatch
    stepCycle(0, 0, 5'h1f, 5'h01, "R2");
    stepCycle(1, 0, 5'h1f, 5'h01, "R2");
    // R8: return instruction enables at once, timer vector
    stepCycle(0, 3, 5'h1f, 5'h04, "R8");
    stepCycle(1, 0, 5'h1f, 5'h04, "R8");
    idle(5);
    // R4: enable dropped by the dispatch
    stepCycle(1, 0, 5'h1f, 5'h04, "R4");
    // R3: priority and every vector
    stepCycle(0, 3, 5'h1f, 5'h05, "R3"); stepCycle(1, 0, 5'h1f, 5'h05, "R3"); idle(5);
    stepCycle(0, 3, 5'h1f, 5'h18, "R3"); stepCycle(1, 0, 5'h1f, 5'h18, "R3"); idle(5);
    stepCycle(0, 3, 5'h1f, 5'h10, "R3"); stepCycle(1, 0, 5'h1f, 5'h10, "R3"); idle(5);
    stepCycle(0, 3, 5'h02, 5'h1f, "R3"); stepCycle(1, 0, 5'h02, 5'h1f, "R3"); idle(5);
    // R6: enable delay
    stepCycle(0, 1, 5'h1f, 5'h01, "R6");
    stepCycle(1, 0, 5'h1f, 5'h01, "R6");          // first boundary: protected
    stepCycle(0, 0, 5'h1f, 5'h01, "R6");
    stepCycle(1, 0, 5'h1f, 5'h01, "R6");          // second boundary: dispatches
    idle(5);
    // R7: disable cancels a scheduled enable
    stepCycle(0, 1, 5'h1f, 5'h00, "R7");
    stepCycle(1, 0, 5'h1f, 5'h00, "R7");
    stepCycle(0, 2, 5'h1f, 5'h01, "R7");
    stepCycle(1, 0, 5'h1f, 5'h01, "R7");
    stepCycle(0, 0, 5'h1f, 5'h01, "R7");
    stepCycle(1, 0, 5'h1f, 5'h01, "R7");
    // R9 / R10: halt, hold, wake with enable off
    stepCycle(0, 4, 5'h1f, 5'h00, "R9");
    for (int k = 0; k < 3; k++) stepCycle(1, 0, 5'h1f, 5'h00, "R9");
    stepCycle(1, 0, 5'h1f, 5'h01, "R10");
    stepCycle(0, 0, 5'h1f, 5'h01, "R10");
    check("R10", "halted after wake", int'(halted), 0);
    // R11: wake with enable on dispatches
    stepCycle(0, 3, 5'h1f, 5'h00, "R11");
    stepCycle(1, 0, 5'h1f, 5'h00, "R11");        // no pending: dispatch nothing
    stepCycle(0, 4, 5'h1f, 5'h00, "R11");
    stepCycle(1, 0, 5'h1f, 5'h00, "R11");
    stepCycle(1, 0, 5'h1f, 5'h02, "R11");
    idle(5);
    // random instruction streams
    for (int n = 0; n < 2500; n++) begin
      logic [4:0] ie, fl;
      int op;
      ie = 5'($urandom);
      fl = 5'($urandom & $urandom);
      op = ($urandom % 10 < 5) ? int'($urandom % 5) : 0;
      if (mBusy != 0)   stepCycle(0, 0, ie, fl, "R5");
      else if (mHalted) stepCycle(1, 0, ie, fl, "R10");
      else begin
        stepCycle(0, op, ie, fl, "R2");
        stepCycle(1, 0, ie, fl, "R3");
      end
    end
    summary();
    $finish;
  end
endmodule